// File: doc/BRIEF.md
# 3D Colour Table Loader

This block is the register front end of a per-pipe three-dimensional colour lookup table with 17 lattice points on each colour axis, which gives 4913 entries. Software stages a new table through a small register bus. It sets an index, optionally with auto-increment, and then streams packed RGB entries through one data port into a staging RAM.

A write to the control register enables the table, binds it to plane 1 and arms a transfer by setting a ready flag. At the next frame-start strobe a copy engine moves the staging RAM, one entry per clock, into the spare bank of a double-banked working RAM. At the end of the copy it swaps banks and clears the ready flag. Lookups therefore always see one whole table.

A lookup read port takes lattice coordinates and returns the stored entry. When the table is disabled it returns the input colour unchanged.

Top module: `lut3d_front`

## Requirements
- R1: After reset the control register (address 2) and the index register (address 0) read 0, and the lookup port passes the input colour through.
- R2: A write to address 0 loads bits 12:0 into the index, and a value above 4912 loads 0 instead. Bit 31 sets the auto-increment mode. A read of address 0 returns the mode in bit 31 and the index in bits 12:0.
- R3: A write to address 1 while ready is clear stores bits 29:0 at the current index. With auto-increment on, the index then advances by one, and from 4912 it goes to 0. With auto-increment off, the index stays where it is.
- R4: An entry holds red in bits 29:20, green in bits 19:10 and blue in bits 9:0. A read of address 1 returns the staged entry at the index in bits 29:0, with bits 31:30 as zero, and does not move the index.
- R5: The control register has enable in bit 0, ready in bit 1, plane-1 bind in bit 2 and error in bit 3. Writing bit 1 as 1 while ready is clear arms a transfer. Ready then stays set until a frameStart pulse. A register read sampled at the 4913th edge after the frame-start edge still shows ready as 1, and one sampled at the 4914th edge shows it as 0.
- R6: While a transfer is armed or copying, lookups return the previous table. Once ready has cleared, they return the new table.
- R7: While ready is set, data writes and control writes with bit 1 set are ignored and the error bit is set. Writing 1 to bit 3 clears the error bit. Other control writes still update enable and bind and leave ready alone.
- R8: The lookup output is registered one clock after its inputs. It is the working entry when the table is enabled and lkColor when it is disabled.
- R9: A lookup addresses the entry r*289 + g*17 + b, and any coordinate above 16 is treated as 16.
- R10: Writing 0 to address 0 clears both the index and the auto-increment mode, so later data writes leave the index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 index, 1 data, 2 control |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid one clock after regRdEn |
| frameStart | input | 1 | Frame-start strobe that launches an armed copy |
| lkNodeR | input | 5 | Red lattice coordinate |
| lkNodeG | input | 5 | Green lattice coordinate |
| lkNodeB | input | 5 | Blue lattice coordinate |
| lkColor | input | 30 | Input colour for the disabled path |
| lkOut | output | 30 | Lookup result |

## Verification
Register read data is due one clock edge after the read strobe, and lookup results are due one edge after the coordinates are presented. The bench drives every input on a falling edge and samples at the next falling edge, so each result is read exactly one rising edge after its stimulus. The clearing of ready is checked to the cycle: the bench counts falling edges from the frame-start edge and places reads so that they sample at the 4912th, 4913th and 4914th rising edges. Lookups issued during the copy window are checked against the previous table.

// File: rtl/lut3d_pkg.sv
package lut3d_pkg;
  localparam int GRID    = 17;
  localparam int COMP_W  = 10;
  localparam int REG_W   = 32;
  localparam int ENTRIES = GRID * GRID * GRID;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int ENTRY_W = 3 * COMP_W;
  localparam int COORD_W = $clog2(GRID);
  localparam int AGE_W   = IDX_W + 1;

  localparam logic [1:0] ADDR_INDEX = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_RDY  = 1;
  localparam int CTRL_BIND = 2;
  localparam int CTRL_ERR  = 3;
  localparam int IDX_AUTO  = 31;

  typedef enum logic [1:0] {CP_IDLE, CP_ARMED, CP_COPY} copyState_t;

  typedef struct packed {
    logic               stageWr;
    logic [IDX_W-1:0]   stageAddr;
    logic [ENTRY_W-1:0] stageData;
    logic               copyWr;
    logic [IDX_W-1:0]   copyAddr;
    logic               swapBank;
  } lutStrobes_t;
endpackage

// File: rtl/lut3d_ctrl.sv
module lut3d_ctrl
  import lut3d_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               frameStart,
  input  logic [ENTRY_W-1:0] stageRdData,
  output logic               lutEnable,
  output lutStrobes_t        stb
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  copyState_t       state;
  logic [IDX_W-1:0] indexQ, copyCnt;
  logic             autoIncQ, bindQ, errQ, readyQ;
  logic             wrIdx, wrData, wrCtrl, dataOk, dataRej, armReq, armRej;
  logic             unusedBits;

  assign unusedBits = ^regWrData[30:IDX_W];

  always_comb begin
    wrIdx   = regWrEn && (regAddr == ADDR_INDEX);
    wrData  = regWrEn && (regAddr == ADDR_DATA);
    wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
    readyQ  = (state != CP_IDLE);
    dataOk  = wrData && !readyQ;
    dataRej = wrData && readyQ;
    armReq  = wrCtrl && regWrData[CTRL_RDY];
    armRej  = armReq && readyQ;
    stb.stageWr   = dataOk;
    stb.stageAddr = indexQ;
    stb.stageData = regWrData[ENTRY_W-1:0];
    stb.copyWr    = (state == CP_COPY);
    stb.copyAddr  = copyCnt;
    stb.swapBank  = (state == CP_COPY) && (copyCnt == LAST);
  end

  // index and auto-increment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ   <= '0;
      autoIncQ <= 1'b0;
    end else if (wrIdx) begin
      indexQ   <= (regWrData[IDX_W-1:0] > LAST) ? '0 : regWrData[IDX_W-1:0];
      autoIncQ <= regWrData[IDX_AUTO];
    end else if (dataOk && autoIncQ) begin
      indexQ   <= (indexQ == LAST) ? '0 : indexQ + 1'b1;
    end
  end

  // control fields and error flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lutEnable <= 1'b0;
      bindQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (wrCtrl && !armRej) begin
        lutEnable <= regWrData[CTRL_EN];
        bindQ     <= regWrData[CTRL_BIND];
      end
      if (dataRej || armRej)                 errQ <= 1'b1;
      else if (wrCtrl && regWrData[CTRL_ERR]) errQ <= 1'b0;
    end
  end

  // copy engine sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CP_IDLE;
      copyCnt <= '0;
    end else begin
      case (state)
        CP_IDLE:  if (armReq) state <= CP_ARMED;
        CP_ARMED: if (frameStart) begin
          state   <= CP_COPY;
          copyCnt <= '0;
        end
        CP_COPY: begin
          if (copyCnt == LAST) begin
            state   <= CP_IDLE;
            copyCnt <= '0;
          end else begin
            copyCnt <= copyCnt + 1'b1;
          end
        end
        default: state <= CP_IDLE;
      endcase
    end
  end

  // register read, one cycle latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (regRdEn) begin
      case (regAddr)
        ADDR_INDEX: regRdData <= {autoIncQ, {(REG_W-1-IDX_W){1'b0}}, indexQ};
        ADDR_DATA:  regRdData <= {{(REG_W-ENTRY_W){1'b0}}, stageRdData};
        ADDR_CTRL:  regRdData <= {{(REG_W-4){1'b0}}, errQ, bindQ, readyQ, lutEnable};
        default:    regRdData <= '0;
      endcase
    end
  end

  // checker counter: cycles spent copying
  logic [AGE_W-1:0] copyAge;
  always_ff @(posedge clk) begin
    if (!rstN || state != CP_COPY) copyAge <= '0;
    else                           copyAge <= copyAge + 1'b1;
  end

  // R5
  copy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyQ) |-> copyAge == AGE_W'(ENTRIES));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    indexQ <= LAST);

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyQ && !stb.swapBank) |=> readyQ);
endmodule

// File: rtl/lut3d_store.sv
module lut3d_store
  import lut3d_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  lutStrobes_t        stb,
  input  logic               lutEnable,
  input  logic [COORD_W-1:0] lkNodeR,
  input  logic [COORD_W-1:0] lkNodeG,
  input  logic [COORD_W-1:0] lkNodeB,
  input  logic [ENTRY_W-1:0] lkColor,
  output logic [ENTRY_W-1:0] lkOut,
  output logic [ENTRY_W-1:0] stageRdData
);
  localparam int BANKS = 2;
  localparam logic [COORD_W-1:0] TOP = COORD_W'(GRID - 1);

  logic [ENTRY_W-1:0] stageMem [ENTRIES];
  logic [ENTRY_W-1:0] bankRd   [BANKS];
  logic [ENTRY_W-1:0] copyData;
  logic [COORD_W-1:0] cr, cg, cb;
  logic [IDX_W-1:0]   lkAddr;
  logic               activeQ;

  always_ff @(posedge clk) begin
    if (stb.stageWr) stageMem[stb.stageAddr] <= stb.stageData;
  end

  assign stageRdData = stageMem[stb.stageAddr];
  assign copyData    = stageMem[stb.copyAddr];

  always_comb begin
    cr = (lkNodeR > TOP) ? TOP : lkNodeR;
    cg = (lkNodeG > TOP) ? TOP : lkNodeG;
    cb = (lkNodeB > TOP) ? TOP : lkNodeB;
    lkAddr = IDX_W'(cr) * IDX_W'(GRID * GRID) + IDX_W'(cg) * IDX_W'(GRID) + IDX_W'(cb);
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ENTRY_W-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (stb.copyWr && (activeQ != 1'(b))) mem[stb.copyAddr] <= copyData;
    end
    assign bankRd[b] = mem[lkAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             activeQ <= 1'b0;
    else if (stb.swapBank) activeQ <= ~activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lkOut <= '0;
    else       lkOut <= lutEnable ? bankRd[activeQ] : lkColor;
  end

  // R7
  stage_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stageWr |-> !stb.copyWr);

  // R8
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(lutEnable)) |-> lkOut == $past(lkColor));

  // R6
  swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ != $past(activeQ)) |-> $past(stb.swapBank));
endmodule

// File: rtl/lut3d_front.sv
module lut3d_front
  import lut3d_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               frameStart,
  input  logic [COORD_W-1:0] lkNodeR,
  input  logic [COORD_W-1:0] lkNodeG,
  input  logic [COORD_W-1:0] lkNodeB,
  input  logic [ENTRY_W-1:0] lkColor,
  output logic [ENTRY_W-1:0] lkOut
);
  lutStrobes_t        stb;
  logic               lutEnable;
  logic [ENTRY_W-1:0] stageRdData;

  lut3d_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameStart(frameStart), .stageRdData(stageRdData),
    .lutEnable(lutEnable), .stb(stb)
  );

  lut3d_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .lutEnable(lutEnable),
    .lkNodeR(lkNodeR), .lkNodeG(lkNodeG), .lkNodeB(lkNodeB),
    .lkColor(lkColor), .lkOut(lkOut), .stageRdData(stageRdData)
  );
endmodule

// File: tb/test_lut3d_front.sv
module test_lut3d_front;
  localparam int N = 4913;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        frameStart = 1'b0;
  logic [4:0]  lkNodeR = '0, lkNodeG = '0, lkNodeB = '0;
  logic [29:0] lkColor = '0, lkOut;

  int checks = 0, errors = 0;
  logic [29:0] tblA [N];
  logic [29:0] tblB [N];

  always #2 clk = ~clk;

  lut3d_front i_lut3d_front (.*);

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nodeIdx(int r, int g, int b);
    int rr = (r > 16) ? 16 : r;
    int gg = (g > 16) ? 16 : g;
    int bb = (b > 16) ? 16 : b;
    return rr * 289 + gg * 17 + bb;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); @(negedge clk);
    d = regRdData; regRdEn = 1'b0;
  endtask

  task automatic lookup(int r, int g, int b, logic [29:0] col, output logic [29:0] d);
    lkNodeR = 5'(r); lkNodeG = 5'(g); lkNodeB = 5'(b); lkColor = col;
    @(posedge clk); @(negedge clk);
    d = lkOut;
  endtask

  task automatic loadTable(bit useB);
    regWrite(2'd0, 32'h8000_0000);
    for (int i = 0; i < N; i++)
      regWrite(2'd1, {2'($urandom()), useB ? tblB[i] : tblA[i]});
    regWrite(2'd0, 32'h0);
  endtask

  task automatic randomLookups(bit useB, string req, int count);
    logic [29:0] got;
    for (int k = 0; k < count; k++) begin
      int r = $urandom_range(0, 16), g = $urandom_range(0, 16), b = $urandom_range(0, 16);
      lookup(r, g, b, 30'($urandom()), got);
      check(req, 32'(got), 32'(useB ? tblB[nodeIdx(r, g, b)] : tblA[nodeIdx(r, g, b)]));
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [29:0] got, col;
    int polls;
    void'($urandom(32'd20251));
    for (int i = 0; i < N; i++) begin
      tblA[i] = 30'($urandom());
      tblB[i] = 30'($urandom());
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd2, rd); check("R1 ctrl", rd, 32'h0);
    regRead(2'd0, rd); check("R1 index", rd, 32'h0);
    col = 30'h2AB_CDEF; lookup(3, 4, 5, col, got); check("R1 passthrough", 32'(got), 32'(col));

    // R2 index wrap and auto flag
    regWrite(2'd0, 32'd4913); regRead(2'd0, rd); check("R2 wrap", rd, 32'h0);
    regWrite(2'd0, 32'h8000_0064); regRead(2'd0, rd); check("R2 auto", rd, 32'h8000_0064);

    // R3 auto advance, R4 packing and readback
    regWrite(2'd1, 32'hFFFF_FFFF); regRead(2'd0, rd); check("R3 advance", rd, 32'h8000_0065);
    regWrite(2'd0, 32'd100); regRead(2'd1, rd); check("R4 readback", rd, 32'h3FFF_FFFF);
    regRead(2'd0, rd); check("R4 no move", rd, 32'd100);
    regWrite(2'd1, 32'hD234_5678); regRead(2'd0, rd); check("R3 hold", rd, 32'd100);
    regRead(2'd1, rd); check("R4 upper zero", rd, 32'h1234_5678);
    regWrite(2'd0, 32'h8000_1330); regWrite(2'd1, 32'h1);
    regRead(2'd0, rd); check("R3 wrap", rd, 32'h8000_0000);

    // R10 zero index clears mode
    regWrite(2'd0, 32'h0); regWrite(2'd1, 32'h5);
    regRead(2'd0, rd); check("R10 index", rd, 32'h0);

    // load first table and arm
    loadTable(1'b0);
    regWrite(2'd2, 32'h7); regRead(2'd2, rd); check("R5 armed", rd, 32'h7);

    // R7 rejected writes while armed
    regWrite(2'd1, 32'h0000_0123); regRead(2'd1, rd); check("R7 no store", rd, 32'(tblA[0]));
    regRead(2'd2, rd); check("R7 err set", rd, 32'hF);
    regWrite(2'd2, 32'hD); regRead(2'd2, rd); check("R7 err clear", rd, 32'h7);
    regWrite(2'd2, 32'h2); regRead(2'd2, rd); check("R7 rearm rejected", rd, 32'hF);
    regWrite(2'd2, 32'hD); regRead(2'd2, rd); check("R7 err clear 2", rd, 32'h7);

    // R5 copy timing, counted from the frame-start edge E0
    frameStart = 1'b1; @(posedge clk); @(negedge clk); frameStart = 1'b0;
    repeat (N - 2) @(negedge clk);
    regRead(2'd2, rd); check("R5 ready at N-1", rd, 32'h7);
    regRead(2'd2, rd); check("R5 ready at N", rd, 32'h7);
    regRead(2'd2, rd); check("R5 cleared at N+1", rd, 32'h5);

    // R9 addressing and clamps
    lookup(0, 0, 0, 30'h0, got); check("R9 origin", 32'(got), 32'(tblA[0]));
    lookup(16, 16, 16, 30'h0, got); check("R9 last", 32'(got), 32'(tblA[N - 1]));
    lookup(31, 20, 17, 30'h0, got); check("R9 clamp", 32'(got), 32'(tblA[N - 1]));
    lookup(1, 0, 0, 30'h0, got); check("R9 red stride", 32'(got), 32'(tblA[289]));
    randomLookups(1'b0, "R9 random", 40);

    // R6 second table: previous contents during copy
    loadTable(1'b1);
    regWrite(2'd2, 32'h7);
    randomLookups(1'b0, "R6 armed old", 5);
    frameStart = 1'b1; @(posedge clk); @(negedge clk); frameStart = 1'b0;
    randomLookups(1'b0, "R6 copy old", 20);
    polls = 0;
    do begin regRead(2'd2, rd); polls++; end while (rd[1] && polls < 6000);
    check("R6 copy done", rd, 32'h5);
    randomLookups(1'b1, "R6 new", 40);

    // R8 disable gives passthrough
    regWrite(2'd2, 32'h0); regRead(2'd2, rd); check("R8 ctrl off", rd, 32'h0);
    for (int k = 0; k < 10; k++) begin
      col = 30'($urandom());
      lookup($urandom_range(0, 16), $urandom_range(0, 16), $urandom_range(0, 16), col, got);
      check("R8 passthrough", 32'(got), 32'(col));
    end
    summary();
  end
endmodule